// File: doc/BRIEF.md
# Low-Power Mode and Clock Controller

This block governs the operating modes of a small microcontroller. Software reaches it through two 8-bit control registers on a simple write/read bus. The first register, the stop-control register, starts a full STOP of the core and peripherals. It also fixes how STOP ends (on a wake-pin edge or while the wake pin is high), which clock mode follows it, whether port outputs float while stopped, and how long the resumed oscillator warms up before the core runs again. The second register, the clock-control register, enables the high- and low-frequency oscillators, picks the system clock, and starts IDLE, a lighter mode in which only the CPU and watchdog stop.

The controller runs STOP entry and release by itself. Once the wake condition occurs, it turns the selected oscillator back on and holds every halt output through a warm-up count. Then it clears the STOP bit on its own. Writes that would switch off the oscillator feeding the system clock are partly ignored. A write that asks for both oscillators off is rejected, and instead the controller pulses an active-low reset request. A reset on `rst` always brings the chip back in high-frequency NORMAL mode.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the stop-control register reads 0x00 and the clock-control register reads {1, LOSC_RST, 0, 0, 1111} (0x8F with the default LOSC_RST=0). All halt outputs and `port_float_o` are 0, `reset_n_o` is 1, the high oscillator is enabled and `clk_sel_o` is 0.
- R2: Stop-control bits 1:0 read as 0 and clock-control bits 3:0 read as 1. Stop-control bit 7 reads 1 exactly while STOP or its warm-up is in progress.
- R3: Writing the stop-control register with bit 7 = 1 raises `cpu_halt_o`, `wdt_halt_o` and `periph_halt_o` from the next cycle. Both oscillator enables are then 0 until the release condition occurs.
- R4: With stop-control bit 6 = 0, STOP is released by a rising edge on `wake_i`. A wake level that was already high when STOP began releases nothing.
- R5: With bit 6 = 1, STOP is released while `wake_i` is high. A STOP write with bit 6 = 1 made while `wake_i` is high does not enter STOP, but its other bits are stored.
- R6: Stop-control bits 3:2 set the warm-up length. Code 01 gives 2^WARM_SHIFT cycles, code 00 gives 3·2^WARM_SHIFT cycles, and codes 10 and 11 behave like 00. The halt outputs stay high for exactly that many cycles after the release cycle, and then bit 7 reads 0.
- R7: Stop-control bit 5 = 0 resumes in NORMAL mode (high oscillator on, `clk_sel_o` = 0). Bit 5 = 1 resumes in SLOW mode (low oscillator on, `clk_sel_o` = 1). A reset during STOP always returns to NORMAL mode.
- R8: With stop-control bit 4 = 0, `port_float_o` is high through STOP and warm-up, meaning outputs float and the internal port input is forced to 0. With bit 4 = 1 it stays low.
- R9: In a clock-control write, clearing the enable (bit 7 high oscillator, bit 6 low oscillator) of the oscillator currently selected has no effect on that bit. The other bits still apply.
- R10: Clock-control bit 5 selects the low-frequency clock (1) or the high-frequency clock (0), but only if that oscillator is enabled after the write. Otherwise the selection is kept. Reading bit 5 returns the clock in use.
- R11: A clock-control write with bits 7:6 = 00 leaves the register unchanged and drives `reset_n_o` low for exactly the following cycle.
- R12: Clock-control bit 4 = 1 starts IDLE: `cpu_halt_o` and `wdt_halt_o` go high while `periph_halt_o` stays low. A pulse on `irq_i` ends IDLE and clears bit 4.
- R13: Bus writes to either register are ignored while STOP or its warm-up is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset (reset pin) |
| wake_i | input | 1 | Wake pin for STOP release |
| irq_i | input | 1 | Interrupt pulse that ends IDLE |
| bus_we_i | input | 1 | Register write strobe |
| bus_sel_i | input | 1 | Register select: 0 stop-control, 1 clock-control |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data of the selected register |
| cpu_halt_o | output | 1 | CPU core halted (STOP or IDLE) |
| wdt_halt_o | output | 1 | Watchdog halted (STOP or IDLE) |
| periph_halt_o | output | 1 | Peripherals halted (STOP only) |
| port_float_o | output | 1 | Port outputs high-impedance, internal port input forced to 0 |
| hosc_en_o | output | 1 | High-frequency oscillator enable |
| losc_en_o | output | 1 | Low-frequency oscillator enable |
| clk_sel_o | output | 1 | System clock select: 0 high, 1 low |
| reset_n_o | output | 1 | Active-low reset request |

## Verification
A corrupted STOP state appears at once on the halt outputs, and also on bit 7 of the stop-control readback. A warm-up counter that is loaded or decremented wrongly shows up as a halt window that is too short or too long, counted in whole cycles from the release edge. If the oscillator-protection logic is wrong, a cycle appears in which the selected clock's enable is low while the core runs. If the reset-request path is wrong, `reset_n_o` falls late, stays low too long, or falls without cause. Every one of these faults shows within one cycle of the write or release that provokes it, except warm-up faults, which show only when the count ends.

// File: rtl/lpm_pkg.sv
`timescale 1ns/1ps
package lpm_pkg;

    // stop-control register bit positions (software-visible)
    localparam int STOP_B = 7;
    localparam int REL_B  = 6;

    // STOP sequencer state
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HALT = 2'd1,
        ST_WARM = 2'd2
    } stop_st_e;

    // stop-control configuration (bits 6:2)
    typedef struct packed {
        logic       rel_lvl;   // 1: level release, 0: edge release
        logic       ret_slow;  // 1: resume in SLOW mode
        logic       keep_out;  // 1: ports keep their drive during STOP
        logic [1:0] wut;       // warm-up code
    } stop_cfg_t;

    // clock-control configuration (bits 7:4)
    typedef struct packed {
        logic hosc;
        logic losc;
        logic sel;             // 0 high clock, 1 low clock
        logic idle;
    } clk_cfg_t;

    // 01 selects the short warm-up; every other code the long one
    function automatic logic warm_is_short(input logic [1:0] code);
        return code == 2'b01;
    endfunction

    // apply a clock-control write without ever disabling the running clock
    function automatic clk_cfg_t clk_write(input clk_cfg_t cur, input logic [3:0] wd);
        clk_cfg_t n;
        n.hosc = wd[3] | ~cur.sel;
        n.losc = wd[2] |  cur.sel;
        if (wd[1])
            n.sel = n.losc ? 1'b1 : cur.sel;
        else
            n.sel = n.hosc ? 1'b0 : cur.sel;
        n.idle = wd[0];
        return n;
    endfunction

    function automatic logic [7:0] pack_stop(input logic active, input stop_cfg_t c);
        return {active, c, 2'b00};
    endfunction

    function automatic logic [7:0] pack_clk(input clk_cfg_t c);
        return {c, 4'hF};
    endfunction

endpackage

// File: rtl/lpm_wake_det.sv
`timescale 1ns/1ps
module lpm_wake_det (
    input  logic clk,
    input  logic rst,
    input  logic wake_i,
    input  logic lvl_mode,
    output logic release_o
);
    logic wake_q;

    always_ff @(posedge clk) begin
        if (rst) wake_q <= 1'b0;
        else     wake_q <= wake_i;
    end

    always_comb begin
        if (lvl_mode) release_o = wake_i;
        else          release_o = wake_i & ~wake_q;
    end
endmodule

// File: rtl/lpm_stop_fsm.sv
`timescale 1ns/1ps
module lpm_stop_fsm
    import lpm_pkg::*;
#(
    parameter int WARM_SHIFT = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       stop_req,
    input  logic       wake_rel,
    input  logic [1:0] wut,
    output stop_st_e   state_o,
    output logic       rel_pulse_o
);
    localparam int CW = WARM_SHIFT + 2;
    localparam logic [CW-1:0] LEN_SHORT = CW'(1) << WARM_SHIFT;
    localparam logic [CW-1:0] LEN_LONG  = CW'(3) << WARM_SHIFT;

    stop_st_e      st_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] load_v;

    assign load_v      = (warm_is_short(wut) ? LEN_SHORT : LEN_LONG) - CW'(1);
    assign rel_pulse_o = (st_q == ST_HALT) && wake_rel;
    assign state_o     = st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_RUN;
            cnt_q <= '0;
        end else begin
            unique case (st_q)
                ST_RUN: begin
                    if (stop_req) st_q <= ST_HALT;
                end
                ST_HALT: begin
                    if (wake_rel) begin
                        st_q  <= ST_WARM;
                        cnt_q <= load_v;
                    end
                end
                ST_WARM: begin
                    if (cnt_q == '0) st_q  <= ST_RUN;
                    else             cnt_q <= cnt_q - CW'(1);
                end
                default: st_q <= ST_RUN;
            endcase
        end
    end
endmodule

// File: rtl/lpm_regs.sv
`timescale 1ns/1ps
module lpm_regs
    import lpm_pkg::*;
#(
    parameter logic LOSC_RST = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic       sel,
    input  logic [7:0] wdata,
    input  logic       wake_i,
    input  logic       stopped,
    input  logic       rel_pulse,
    input  logic       irq_i,
    output stop_cfg_t  stop_cfg_o,
    output clk_cfg_t   clk_cfg_o,
    output logic       stop_req_o,
    output logic       reset_n_o
);
    stop_cfg_t stop_q;
    clk_cfg_t  clk_q;
    clk_cfg_t  clk_wr;
    logic      wr_stop, wr_clk, both_off, rstn_q;
    logic      unused_low;

    assign unused_low = ^wdata[1:0];

    assign wr_stop  = we && !sel && !stopped;
    assign wr_clk   = we &&  sel && !stopped;
    assign both_off = wdata[7:6] == 2'b00;
    assign clk_wr   = clk_write(clk_q, wdata[7:4]);

    // a level-release STOP is not entered while the wake pin is already high
    assign stop_req_o = wr_stop && wdata[STOP_B] && !(wdata[REL_B] && wake_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            stop_q <= '0;
            clk_q  <= '{hosc: 1'b1, losc: LOSC_RST, sel: 1'b0, idle: 1'b0};
            rstn_q <= 1'b1;
        end else begin
            rstn_q <= !(wr_clk && both_off);
            if (wr_stop)
                stop_q <= stop_cfg_t'(wdata[6:2]);
            if (rel_pulse) begin
                if (stop_q.ret_slow) begin
                    clk_q.losc <= 1'b1;
                    clk_q.sel  <= 1'b1;
                end else begin
                    clk_q.hosc <= 1'b1;
                    clk_q.sel  <= 1'b0;
                end
            end else if (wr_clk && !both_off) begin
                clk_q <= clk_wr;
            end
            if (irq_i)
                clk_q.idle <= 1'b0;
        end
    end

    assign stop_cfg_o = stop_q;
    assign clk_cfg_o  = clk_q;
    assign reset_n_o  = rstn_q;
endmodule

// File: rtl/lpm_ctrl.sv
`timescale 1ns/1ps
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int   WARM_SHIFT = 10,
    parameter logic LOSC_RST   = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wake_i,
    input  logic       irq_i,
    input  logic       bus_we_i,
    input  logic       bus_sel_i,
    input  logic [7:0] bus_wdata_i,
    output logic [7:0] bus_rdata_o,
    output logic       cpu_halt_o,
    output logic       wdt_halt_o,
    output logic       periph_halt_o,
    output logic       port_float_o,
    output logic       hosc_en_o,
    output logic       losc_en_o,
    output logic       clk_sel_o,
    output logic       reset_n_o
);
    stop_cfg_t stop_cfg;
    clk_cfg_t  clk_cfg;
    stop_st_e  st;
    logic      stop_req, rel_pulse, wake_rel, stopped, frozen;

    assign stopped = st != ST_RUN;
    assign frozen  = st == ST_HALT;

    lpm_wake_det u_wake (
        .clk       (clk),
        .rst       (rst),
        .wake_i    (wake_i),
        .lvl_mode  (stop_cfg.rel_lvl),
        .release_o (wake_rel)
    );

    lpm_stop_fsm #(.WARM_SHIFT(WARM_SHIFT)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .stop_req    (stop_req),
        .wake_rel    (wake_rel),
        .wut         (stop_cfg.wut),
        .state_o     (st),
        .rel_pulse_o (rel_pulse)
    );

    lpm_regs #(.LOSC_RST(LOSC_RST)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .we         (bus_we_i),
        .sel        (bus_sel_i),
        .wdata      (bus_wdata_i),
        .wake_i     (wake_i),
        .stopped    (stopped),
        .rel_pulse  (rel_pulse),
        .irq_i      (irq_i),
        .stop_cfg_o (stop_cfg),
        .clk_cfg_o  (clk_cfg),
        .stop_req_o (stop_req),
        .reset_n_o  (reset_n_o)
    );

    assign bus_rdata_o   = bus_sel_i ? pack_clk(clk_cfg) : pack_stop(stopped, stop_cfg);
    assign cpu_halt_o    = stopped | clk_cfg.idle;
    assign wdt_halt_o    = stopped | clk_cfg.idle;
    assign periph_halt_o = stopped;
    assign port_float_o  = stopped & ~stop_cfg.keep_out;
    assign hosc_en_o     = clk_cfg.hosc & ~frozen;
    assign losc_en_o     = clk_cfg.losc & ~frozen;
    assign clk_sel_o     = clk_cfg.sel;
endmodule

// File: rtl/lpm_ctrl_chk.sv
`timescale 1ns/1ps
module lpm_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       wake_i,
    input logic       bus_we_i,
    input logic       bus_sel_i,
    input logic [7:0] bus_wdata_i,
    input logic       cpu_halt_o,
    input logic       wdt_halt_o,
    input logic       periph_halt_o,
    input logic       port_float_o,
    input logic       hosc_en_o,
    input logic       losc_en_o,
    input logic       clk_sel_o,
    input logic       reset_n_o
);
    // R3
    stop_halts_core_chk: assert property (@(posedge clk) disable iff (rst)
        periph_halt_o |-> (cpu_halt_o && wdt_halt_o));

    // R3
    stop_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we_i && !bus_sel_i && bus_wdata_i[7] && !bus_wdata_i[6] && !periph_halt_o)
        |=> periph_halt_o);

    // R5
    level_veto_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we_i && !bus_sel_i && bus_wdata_i[7] && bus_wdata_i[6] && wake_i && !periph_halt_o)
        |=> !periph_halt_o);

    // R8
    float_only_stopped_chk: assert property (@(posedge clk) disable iff (rst)
        port_float_o |-> periph_halt_o);

    // R9
    running_clock_on_chk: assert property (@(posedge clk) disable iff (rst)
        !periph_halt_o |-> (clk_sel_o ? losc_en_o : hosc_en_o));

    // R11
    reset_cause_chk: assert property (@(posedge clk) disable iff (rst)
        !reset_n_o |-> $past(bus_we_i && bus_sel_i && bus_wdata_i[7:6] == 2'b00 && !periph_halt_o));

    // R11
    reset_request_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we_i && bus_sel_i && bus_wdata_i[7:6] == 2'b00 && !periph_halt_o) |=> !reset_n_o);
endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .wake_i        (wake_i),
    .bus_we_i      (bus_we_i),
    .bus_sel_i     (bus_sel_i),
    .bus_wdata_i   (bus_wdata_i),
    .cpu_halt_o    (cpu_halt_o),
    .wdt_halt_o    (wdt_halt_o),
    .periph_halt_o (periph_halt_o),
    .port_float_o  (port_float_o),
    .hosc_en_o     (hosc_en_o),
    .losc_en_o     (losc_en_o),
    .clk_sel_o     (clk_sel_o),
    .reset_n_o     (reset_n_o)
);

// File: tb/lpm_ctrl_bench.sv
`timescale 1ns/1ps
module lpm_ctrl_bench;
    localparam int WS    = 4;
    localparam int SHORT = 1 << WS;
    localparam int LONG  = 3 << WS;

    localparam logic [2:0] K_RD   = 3'd0;
    localparam logic [2:0] K_HALT = 3'd1;   // {cpu, wdt, periph, float}
    localparam logic [2:0] K_OSC  = 3'd2;   // {hosc, losc, sel}
    localparam logic [2:0] K_RSTN = 3'd3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wake = 1'b0, irq = 1'b0, we = 1'b0, sel = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       cpu_h, wdt_h, per_h, flt, hosc, losc, csel, rstn;
    int         checks = 0, errors = 0;
    bit         done = 0;

    typedef struct packed {
        logic [7:0] req;
        logic [2:0] kind;
        logic [7:0] exp;
    } item_t;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    lpm_ctrl #(.WARM_SHIFT(WS), .LOSC_RST(1'b0)) u_lpm_ctrl (
        .clk(clk), .rst(rst), .wake_i(wake), .irq_i(irq),
        .bus_we_i(we), .bus_sel_i(sel), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .cpu_halt_o(cpu_h), .wdt_halt_o(wdt_h), .periph_halt_o(per_h),
        .port_float_o(flt), .hosc_en_o(hosc), .losc_en_o(losc),
        .clk_sel_o(csel), .reset_n_o(rstn)
    );

    function automatic logic [7:0] probe(input logic [2:0] k);
        case (k)
            K_RD:    return rdata;
            K_HALT:  return {4'b0, cpu_h, wdt_h, per_h, flt};
            K_OSC:   return {5'b0, hosc, losc, csel};
            default: return {7'b0, rstn};
        endcase
    endfunction

    // monitor: compare queued expectations away from the active edge
    always @(negedge clk) begin
        while (sb_q.size() != 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (probe(it.kind) !== it.exp) begin
                errors++;
                $display("FAIL R%0d kind %0d actual %h expected %h", it.req, it.kind, probe(it.kind), it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic s, input logic [7:0] d);
        step(); we = 1'b1; sel = s; wdata = d;
        step(); we = 1'b0;
    endtask

    task automatic expect_v(input logic [2:0] k, input logic [7:0] e, input int r);
        sb_q.push_back('{req: 8'(r), kind: k, exp: e});
    endtask

    task automatic expect_rd(input logic s, input logic [7:0] e, input int r);
        sel = s;
        expect_v(K_RD, e, r);
        settle();
    endtask

    task automatic settle();
        @(negedge clk); #0.5;
    endtask

    task automatic cmp(input int r, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL R%0d actual %0d expected %0d", r, act, exp);
        end
    endtask

    // count halted cycles (and floating ones) after the release edge
    task automatic count_warm(output int n, output int f);
        n = 0; f = 0;
        @(posedge clk);
        forever begin
            @(negedge clk);
            if (!per_h || n > 10000) break;
            n++;
            if (flt) f++;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n, f;
        repeat (3) step();
        rst = 1'b0;
        step();

        // R1 reset state, R2 read-back constants
        expect_v(K_HALT, 8'h00, 1); expect_v(K_OSC, 8'h04, 1); expect_v(K_RSTN, 8'h01, 1);
        settle();
        expect_rd(1'b0, 8'h00, 1);
        expect_rd(1'b1, 8'h8F, 2);

        // R9: clearing the running high oscillator is ignored, low one turns on
        wr(1'b1, 8'h40); expect_rd(1'b1, 8'hCF, 9);
        // R10: switch to low clock
        wr(1'b1, 8'hE0); expect_rd(1'b1, 8'hEF, 10);
        expect_v(K_OSC, 8'h07, 10); settle();
        // R9: high oscillator may stop while the low clock runs
        wr(1'b1, 8'h60); expect_rd(1'b1, 8'h6F, 9);
        // R9: low oscillator protected, selection returns to high
        wr(1'b1, 8'h80); expect_rd(1'b1, 8'hCF, 9);
        wr(1'b1, 8'h80); expect_rd(1'b1, 8'h8F, 9);
        // R10: low clock requested with its oscillator off -> kept high
        wr(1'b1, 8'hA0); expect_rd(1'b1, 8'h8F, 10);

        // R11: both oscillators off -> one-cycle reset request, no change
        wr(1'b1, 8'h3F);
        expect_v(K_RSTN, 8'h00, 11); settle();
        expect_v(K_RSTN, 8'h01, 11); settle();
        expect_rd(1'b1, 8'h8F, 11);

        // R12: IDLE then interrupt
        wr(1'b1, 8'h90);
        expect_v(K_HALT, 8'h0C, 12); settle();
        expect_rd(1'b1, 8'h9F, 12);
        step(); irq = 1'b1; step(); irq = 1'b0;
        expect_v(K_HALT, 8'h00, 12); settle();
        expect_rd(1'b1, 8'h8F, 12);

        // R3 entry, edge release, long warm-up, NORMAL return, floating ports
        wr(1'b0, 8'h80);
        expect_v(K_HALT, 8'h0F, 3); expect_v(K_OSC, 8'h00, 3); settle();
        expect_rd(1'b0, 8'h80, 2);
        // R13: write during STOP ignored
        wr(1'b1, 8'hE0); expect_rd(1'b1, 8'h8F, 13);
        step(); wake = 1'b1;
        count_warm(n, f);
        cmp(6, n, LONG);   // R6 code 00
        cmp(8, f, LONG);   // R8 floating through warm-up
        expect_v(K_HALT, 8'h00, 6); expect_v(K_OSC, 8'h04, 7); settle();
        expect_rd(1'b0, 8'h00, 6);
        step(); wake = 1'b0;

        // R4: level held from before entry does not release; SLOW return, short warm-up
        step(); wake = 1'b1; step(); step();
        wr(1'b0, 8'hB4);
        repeat (6) step();
        expect_v(K_HALT, 8'h0E, 4); settle();   // R8 keep: no float
        step(); wake = 1'b0; step(); wake = 1'b1;
        count_warm(n, f);
        cmp(6, n, SHORT);  // R6 code 01
        cmp(8, f, 0);
        expect_v(K_OSC, 8'h07, 7); settle();
        expect_rd(1'b0, 8'h34, 7);
        step(); wake = 1'b0;

        // R5: level mode write with wake high is not entered
        step(); wake = 1'b1;
        wr(1'b0, 8'hC0);
        expect_v(K_HALT, 8'h00, 5); settle();
        expect_rd(1'b0, 8'h40, 5);
        step(); wake = 1'b0;
        wr(1'b0, 8'hD8);
        repeat (5) step();
        expect_v(K_HALT, 8'h0E, 5); settle();
        step(); wake = 1'b1;
        count_warm(n, f);
        cmp(6, n, LONG);   // R6 reserved code 10 acts as long
        expect_v(K_OSC, 8'h06, 7); settle();
        expect_rd(1'b0, 8'h58, 5);
        step(); wake = 1'b0;

        // R7: reset during STOP returns NORMAL despite SLOW return selected
        wr(1'b0, 8'hA0);
        expect_v(K_HALT, 8'h0F, 7); settle();
        step(); rst = 1'b1; step(); step(); rst = 1'b0;
        expect_v(K_OSC, 8'h04, 7); expect_v(K_HALT, 8'h00, 7); settle();
        expect_rd(1'b0, 8'h00, 7);

        step();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule